// File: doc/BRIEF.md
# Dispatch Slot Steering

This block sits between group formation and the issue queues. A dispatch group has five micro-op slots, numbered 0 to 4. Each slot carries a valid bit, a three-bit unit class and a cracked flag. The block sends each micro-op to one issue queue. The choice depends only on the micro-op's class and the slot it occupies; there is no load balancing between queues. For each slot the block raises one bit of a queue-select vector, or no bit at all.

The block also checks that the group is legal. A class placed in a slot that cannot carry it raises a violation flag, and that slot gets no queue. A cracked flag on slot s means the micro-ops in slots s and s+1 are the two halves of one instruction. The halves must dispatch together. If they cannot both sit legally in this group, the group is ended early at slot s. The block reports the cut position and enables nothing from that slot onward, so group formation can move the pair to the next group.

All results are computed combinationally and registered once.

Top module: `dispatch_steer`

## Requirements
- R1: The queue-select bit positions are: 0 = shared load/store and fixed-point queue A, 1 = shared queue B, 2 = float queue A, 3 = float queue B, 4 = condition-register queue, 5 = branch queue, 6 = vector permute queue, 7 = vector arithmetic queue. Load/store (class 0) and fixed-point (class 1) micro-ops in slots 0 or 3 select bit 0, and in slots 1 or 2 select bit 1. Float (class 2) micro-ops in slots 0 or 3 select bit 2, and in slots 1 or 2 select bit 3.
- R2: A condition-register micro-op (class 3) in slot 0 or 1 selects bit 4. In any other slot it raises the violation flag and gets no queue.
- R3: A branch micro-op (class 4) in slot 4 selects bit 5. In slots 0 to 3 it raises the violation flag and gets no queue.
- R4: Any valid micro-op in slot 4 that is not a branch raises the violation flag and gets no queue.
- R5: A vector permute micro-op (class 5) selects bit 6, and a vector arithmetic micro-op (class 6) selects bit 7, from any of slots 0 to 3.
- R6: An invalid slot gets no queue and never raises the violation flag. A valid micro-op of reserved class 7 raises the violation flag and gets no queue.
- R7: A cracked pair at slots s and s+1 whose halves are both valid and both legal in their slots is steered normally, and the early-close flag stays low.
- R8: If the pair starting at slot s does not fit (s is 4, the sibling is invalid, or either half is illegal in its slot), the block raises the early-close flag and sets the cut index to s. Slots s and above get no queue, and illegal micro-ops in those slots do not raise the violation flag.
- R9: When several cracked pairs fail, the cut index is the lowest failing slot.
- R10: All outputs change on the clock edge after the inputs change. Reset clears every output to zero.
- R11: Each slot's queue select has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | 5 | Valid bit for each slot |
| slot_cls_i | input | 5x3 | Unit class for each slot |
| slot_crk_i | input | 5 | Marks the first half of a cracked pair; its sibling is in the next slot |
| slot_qsel_o | output | 5x8 | One-hot queue select for each slot; all zero means no enable |
| viol_o | output | 1 | A kept slot holds a class that is illegal for that slot |
| close_o | output | 1 | The group must end early because a cracked pair does not fit |
| cut_o | output | 3 | First slot deferred to the next group when close_o is high |

## Verification
There is one register stage, so every result (queue selects, violation, early close and cut index) is due on the first rising edge after the inputs are applied. The bench drives each group on a falling edge and samples the outputs on the next falling edge, half a period after the edge that loads them. For the latency requirement, the bench also samples two nanoseconds after new inputs are applied. At that point the outputs must still show the previous group's result.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int N_SLOTS = 5;
  localparam int CLS_W   = 3;
  localparam int N_Q     = 8;
  localparam int CUT_W   = $clog2(N_SLOTS);
  localparam int BR_SLOT = N_SLOTS - 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_LS    = 3'd0,
    CLS_FX    = 3'd1,
    CLS_FP    = 3'd2,
    CLS_CR    = 3'd3,
    CLS_BR    = 3'd4,
    CLS_VPERM = 3'd5,
    CLS_VALU  = 3'd6,
    CLS_RSV   = 3'd7
  } cls_e;

  localparam int Q_LSFX0 = 0;
  localparam int Q_LSFX1 = 1;
  localparam int Q_FP0   = 2;
  localparam int Q_FP1   = 3;
  localparam int Q_CR    = 4;
  localparam int Q_BR    = 5;
  localparam int Q_VPERM = 6;
  localparam int Q_VALU  = 7;
endpackage

// File: rtl/steer_slot_map.sv
module steer_slot_map
  import steer_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic             vld_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             legal_o,
  output logic [N_Q-1:0]   qsel_o
);
  // slots 1,2 feed the second queue of a pair; 0,3 the first
  localparam bit PAIR_HI = (SLOT == 1) || (SLOT == 2);
  localparam bit BR_POS  = (SLOT == BR_SLOT);
  localparam bit CR_POS  = (SLOT <= 1);
  localparam int Q_SH    = PAIR_HI ? Q_LSFX1 : Q_LSFX0;
  localparam int Q_F     = PAIR_HI ? Q_FP1 : Q_FP0;

  logic           legal;
  logic [N_Q-1:0] q;

  always_comb begin
    legal = 1'b0;
    q     = '0;
    case (cls_e'(cls_i))
      CLS_LS, CLS_FX: if (!BR_POS) begin legal = 1'b1; q[Q_SH] = 1'b1; end
      CLS_FP:         if (!BR_POS) begin legal = 1'b1; q[Q_F]  = 1'b1; end
      CLS_CR:         if (CR_POS)  begin legal = 1'b1; q[Q_CR] = 1'b1; end
      CLS_BR:         if (BR_POS)  begin legal = 1'b1; q[Q_BR] = 1'b1; end
      CLS_VPERM:      if (!BR_POS) begin legal = 1'b1; q[Q_VPERM] = 1'b1; end
      CLS_VALU:       if (!BR_POS) begin legal = 1'b1; q[Q_VALU]  = 1'b1; end
      default: ;
    endcase
  end

  assign legal_o = legal;
  assign qsel_o  = (vld_i && legal) ? q : '0;
endmodule

// File: rtl/steer_crack_cut.sv
module steer_crack_cut
  import steer_pkg::*;
(
  input  logic [N_SLOTS-1:0] vld_i,
  input  logic [N_SLOTS-1:0] crk_i,
  input  logic [N_SLOTS-1:0] legal_i,
  output logic               cut_vld_o,
  output logic [CUT_W-1:0]   cut_idx_o
);
  logic [N_SLOTS-1:0] bad;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_bad
    if (s == N_SLOTS - 1) begin : g_last
      assign bad[s] = vld_i[s] & crk_i[s];
    end else begin : g_mid
      assign bad[s] = vld_i[s] & crk_i[s] &
                      ~(vld_i[s+1] & legal_i[s] & legal_i[s+1]);
    end
  end

  // lowest failing pair wins
  always_comb begin
    cut_vld_o = 1'b0;
    cut_idx_o = '0;
    for (int s = N_SLOTS - 1; s >= 0; s--) begin
      if (bad[s]) begin
        cut_vld_o = 1'b1;
        cut_idx_o = CUT_W'(s);
      end
    end
  end
endmodule

// File: rtl/dispatch_steer.sv
module dispatch_steer
  import steer_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SLOTS-1:0]            slot_vld_i,
  input  logic [N_SLOTS-1:0][CLS_W-1:0] slot_cls_i,
  input  logic [N_SLOTS-1:0]            slot_crk_i,
  output logic [N_SLOTS-1:0][N_Q-1:0]   slot_qsel_o,
  output logic                          viol_o,
  output logic                          close_o,
  output logic [CUT_W-1:0]              cut_o
);
  logic [N_SLOTS-1:0]          legal;
  logic [N_SLOTS-1:0]          keep;
  logic [N_SLOTS-1:0][N_Q-1:0] qsel_c;
  logic [N_SLOTS-1:0][N_Q-1:0] qsel_n;
  logic                        cut_vld;
  logic [CUT_W-1:0]            cut_idx;
  logic                        viol_n;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    steer_slot_map #(.SLOT(s)) u_map (
      .vld_i   (slot_vld_i[s]),
      .cls_i   (slot_cls_i[s]),
      .legal_o (legal[s]),
      .qsel_o  (qsel_c[s])
    );
    assign keep[s]   = !(cut_vld && (CUT_W'(s) >= cut_idx));
    assign qsel_n[s] = keep[s] ? qsel_c[s] : '0;
  end

  steer_crack_cut u_cut (
    .vld_i     (slot_vld_i),
    .crk_i     (slot_crk_i),
    .legal_i   (legal),
    .cut_vld_o (cut_vld),
    .cut_idx_o (cut_idx)
  );

  assign viol_n = |(slot_vld_i & ~legal & keep);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_qsel_o <= '0;
      viol_o      <= 1'b0;
      close_o     <= 1'b0;
      cut_o       <= '0;
    end else begin
      slot_qsel_o <= qsel_n;
      viol_o      <= viol_n;
      close_o     <= cut_vld;
      cut_o       <= cut_idx;
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_ast
    AST_QSEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(slot_qsel_o[s])); // R11
    AST_IDLE_NO_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_vld_i[s] |=> slot_qsel_o[s] == '0); // R6
  end

  AST_S4_NONBR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_crk_i == '0 && slot_vld_i[BR_SLOT] && slot_cls_i[BR_SLOT] != CLS_BR)
    |=> viol_o && slot_qsel_o[BR_SLOT] == '0); // R4
  AST_CR_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_crk_i == '0 && slot_vld_i[2] && slot_cls_i[2] == CLS_CR)
    |=> viol_o && slot_qsel_o[2] == '0); // R2
  AST_PAIR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_crk_i == '0 && slot_vld_i[0] &&
     (slot_cls_i[0] == CLS_LS || slot_cls_i[0] == CLS_FX))
    |=> slot_qsel_o[0][Q_LSFX0]); // R1
  AST_CUT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_o && cut_o < CUT_W'(N_SLOTS)) |-> slot_qsel_o[cut_o] == '0); // R8
  AST_NO_CRK_NO_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_crk_i == '0 |=> !close_o); // R7
endmodule

// File: tb/tb_dispatch_steer.sv
module tb_dispatch_steer;
  localparam logic [2:0] LS = 3'd0, FX = 3'd1, FP = 3'd2, CR = 3'd3,
                         BR = 3'd4, VP = 3'd5, VA = 3'd6, RS = 3'd7;
  localparam int NONE = -1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        vld = '0;
  logic [4:0][2:0]   cls = '0;
  logic [4:0]        crk = '0;
  logic [4:0][7:0]   qsel;
  logic              viol, close;
  logic [2:0]        cut;
  int                n_chk = 0;
  int                n_bad = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  dispatch_steer dut (
    .clk_i(clk), .rst_ni(rst_n), .slot_vld_i(vld), .slot_cls_i(cls),
    .slot_crk_i(crk), .slot_qsel_o(qsel), .viol_o(viol), .close_o(close),
    .cut_o(cut)
  );

  function automatic logic [7:0] qb(int i);
    return (i < 0) ? 8'h00 : (8'h01 << i);
  endfunction

  function automatic logic [4:0][7:0] qv(int a0, int a1, int a2, int a3, int a4);
    logic [4:0][7:0] r;
    r[0] = qb(a0); r[1] = qb(a1); r[2] = qb(a2); r[3] = qb(a3); r[4] = qb(a4);
    return r;
  endfunction

  function automatic logic [4:0][2:0] cv(logic [2:0] c0, logic [2:0] c1,
      logic [2:0] c2, logic [2:0] c3, logic [2:0] c4);
    logic [4:0][2:0] r;
    r[0] = c0; r[1] = c1; r[2] = c2; r[3] = c3; r[4] = c4;
    return r;
  endfunction

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run(string req, logic [4:0] v, logic [4:0][2:0] c, logic [4:0] k,
                     logic [4:0][7:0] eq, logic ev, logic ec, logic [2:0] ecut);
    @(negedge clk);
    vld = v; cls = c; crk = k;
    @(negedge clk);
    chk(req, "qsel", 64'(qsel), 64'(eq));
    chk(req, "viol", 64'(viol), 64'(ev));
    chk(req, "close", 64'(close), 64'(ec));
    if (ec) chk(req, "cut", 64'(cut), 64'(ecut));
  endtask

  task automatic t_reset;
    chk("R10", "reset qsel", 64'(qsel), 64'h0);
    chk("R10", "reset flags", {61'h0, viol, close, 1'b0}, 64'h0);
    chk("R10", "reset cut", 64'(cut), 64'h0);
  endtask

  task automatic t_pairs;
    run("R1", 5'b01111, cv(LS, FX, FP, FP, LS), '0, qv(0, 1, 3, 2, NONE), 0, 0, 0);
    run("R1", 5'b01111, cv(FP, FP, LS, FX, LS), '0, qv(2, 3, 1, 0, NONE), 0, 0, 0);
  endtask

  task automatic t_cr;
    run("R2", 5'b00011, cv(CR, CR, LS, LS, LS), '0, qv(4, 4, NONE, NONE, NONE), 0, 0, 0);
    run("R2", 5'b00101, cv(FX, LS, CR, LS, LS), '0, qv(0, NONE, NONE, NONE, NONE), 1, 0, 0);
  endtask

  task automatic t_branch;
    run("R3", 5'b10001, cv(LS, LS, LS, LS, BR), '0, qv(0, NONE, NONE, NONE, 5), 0, 0, 0);
    run("R3", 5'b00010, cv(LS, BR, LS, LS, LS), '0, qv(NONE, NONE, NONE, NONE, NONE), 1, 0, 0);
    run("R4", 5'b10000, cv(LS, LS, LS, LS, FX), '0, qv(NONE, NONE, NONE, NONE, NONE), 1, 0, 0);
  endtask

  task automatic t_vector;
    run("R5", 5'b01111, cv(VP, VA, VP, VA, LS), '0, qv(6, 7, 6, 7, NONE), 0, 0, 0);
    run("R4", 5'b10000, cv(LS, LS, LS, LS, VA), '0, qv(NONE, NONE, NONE, NONE, NONE), 1, 0, 0);
  endtask

  task automatic t_invalid;
    run("R6", 5'b00000, cv(CR, CR, CR, CR, CR), '0, qv(NONE, NONE, NONE, NONE, NONE), 0, 0, 0);
    run("R6", 5'b00001, cv(RS, LS, LS, LS, LS), '0, qv(NONE, NONE, NONE, NONE, NONE), 1, 0, 0);
  endtask

  task automatic t_crack_fit;
    run("R7", 5'b00111, cv(LS, FX, FX, LS, LS), 5'b00010, qv(0, 1, 1, NONE, NONE), 0, 0, 0);
    run("R7", 5'b00011, cv(CR, CR, LS, LS, LS), 5'b00001, qv(4, 4, NONE, NONE, NONE), 0, 0, 0);
  endtask

  task automatic t_crack_split;
    run("R8", 5'b11111, cv(LS, LS, FX, FX, FX), 5'b01000, qv(0, 1, 1, NONE, NONE), 0, 1, 3);
    run("R8", 5'b00111, cv(LS, CR, CR, LS, LS), 5'b00010, qv(0, NONE, NONE, NONE, NONE), 0, 1, 1);
    run("R8", 5'b10000, cv(LS, LS, LS, LS, BR), 5'b10000, qv(NONE, NONE, NONE, NONE, NONE), 0, 1, 4);
  endtask

  task automatic t_crack_first;
    run("R9", 5'b01111, cv(FX, FX, CR, FX, LS), 5'b00110, qv(0, NONE, NONE, NONE, NONE), 0, 1, 1);
    run("R9", 5'b00001, cv(FX, LS, LS, LS, LS), 5'b00001, qv(NONE, NONE, NONE, NONE, NONE), 0, 1, 0);
  endtask

  task automatic t_latency;
    run("R10", 5'b00011, cv(CR, CR, LS, LS, LS), '0, qv(4, 4, NONE, NONE, NONE), 0, 0, 0);
    @(negedge clk);
    vld = 5'b01111; cls = cv(VP, VA, VP, VA, LS); crk = '0;
    #2;
    chk("R10", "before edge", 64'(qsel), 64'(qv(4, 4, NONE, NONE, NONE)));
    @(negedge clk);
    chk("R10", "after edge", 64'(qsel), 64'(qv(6, 7, 6, 7, NONE)));
  endtask

  initial begin
    #500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pairs();
    t_cr();
    t_branch();
    t_vector();
    t_invalid();
    t_crack_fit();
    t_crack_split();
    t_crack_first();
    t_latency();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule